// File: doc/BRIEF.md
# Latched BCD Dot-Matrix Character Decoder

This block stores a 4-bit code and a decimal-point request in a level-controlled memory. It turns the stored code into a lit-dot pattern for a character cell that is 4 columns wide and 7 rows tall. The decimal point is driven on its own output bit, outside the 28-dot cell.

The store is modelled synchronously. The latch-enable pin is active low and is sampled on every rising system-clock edge. On each edge where the sampled enable is low, the store takes the present data and decimal-point inputs. On each edge where it is high, the store keeps its contents.

The outputs decode the stored value directly. They therefore change on the clock edge that captures new data. The last low-enable edge before enable rises is the effective capture point. Several cells can share the data lines and each be loaded through its own enable.

Top module: `dotmx_char`

## Requirements
- R1: While `rst_n` is low, the store resets to code 11 (a blank code) with the decimal point off. After reset, `dots_o` is all zero and `dp_o` is 0.
- R2: On a rising `clk` edge where `le_n` is low, the store takes `bcd_in` and `dp_n`. The outputs show the new value from that edge on, so there is one edge of latency.
- R3: On a rising `clk` edge where `le_n` is high, changes on `bcd_in` and `dp_n` have no effect. The outputs keep the value from the last low-enable edge.
- R4: Dot `dots_o[row*4+col]` is lit when it is 1. Row 0 is the top row and column 0 is the left column. Codes 0 to 9 show the decimal digits with 8421 weighting. As 28-bit hex values, the glyphs are:
  - 0 = 6999996, 1 = E444464, 2 = F124896, 3 = 6986896, 4 = 888F999
  - 5 = 698871F, 6 = 6997116, 7 = 222448F, 8 = 6996996, 9 = 688E996
- R5: Code 10 shows a minus sign. Only row 3 is lit: `dots_o` = 000F000 hex.
- R6: Code 15 is the lamp test. All 28 dots are lit: `dots_o` = FFFFFFF hex.
- R7: Codes 11, 12, 13 and 14 are blank. `dots_o` is all zero for each of them.
- R8: `dp_n` is active low. The stored bit is captured on the same edges as the code. `dp_o` is 1 exactly when the captured `dp_n` was 0, whatever the code is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| le_n | input | 1 | Latch enable, active low; the store follows the inputs while it is low |
| bcd_in | input | 4 | Character code |
| dp_n | input | 1 | Decimal-point request, active low |
| dots_o | output | 28 | Dot pattern, bit index row*4+col, 1 = lit |
| dp_o | output | 1 | Decimal-point dot drive, 1 = lit |

## Verification
Capture and hold can meet in the same cycle. The bench provokes this by raising `le_n` and changing `bcd_in` and `dp_n` at the same falling edge. The outputs must then hold the value taken at the previous low edge, not the new data.

The decimal point and the code are also captured on the same edge. The bench judges them separately, so a decimal point that is lost or delayed is reported on its own even when the glyph is correct.

A behavioural model in the bench predicts both outputs. The bench compares them with the model on every clock.

// File: rtl/dotmx_pkg.sv
package dotmx_pkg;
  localparam int CODE_W = 4;
  localparam int COLS   = 4;
  localparam int ROWS   = 7;
  localparam int DOTS   = COLS * ROWS;

  localparam logic [CODE_W-1:0] CODE_MINUS = 4'd10;
  localparam logic [CODE_W-1:0] CODE_TEST  = 4'd15;
  localparam logic [CODE_W-1:0] CODE_RESET = 4'd11;

  typedef logic [DOTS-1:0] glyph_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              dp;
  } cell_t;

  // Full glyph per code, bit index row*COLS+col, row 0 on top.
  function automatic glyph_t glyph_of(input logic [CODE_W-1:0] c);
    glyph_t g;
    case (c)
      4'd0:    g = 28'h6999996;
      4'd1:    g = 28'hE444464;
      4'd2:    g = 28'hF124896;
      4'd3:    g = 28'h6986896;
      4'd4:    g = 28'h888F999;
      4'd5:    g = 28'h698871F;
      4'd6:    g = 28'h6997116;
      4'd7:    g = 28'h222448F;
      4'd8:    g = 28'h6996996;
      4'd9:    g = 28'h688E996;
      4'd10:   g = 28'h000F000;
      4'd15:   g = '1;
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/dotmx_store.sv
module dotmx_store
  import dotmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              dp_n,
  output cell_t             cell_q
);
  cell_t cell_d;

  always_comb begin
    cell_d.code = code_in;
    cell_d.dp   = ~dp_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_q.code <= CODE_RESET;
      cell_q.dp   <= 1'b0;
    end else if (!le_n) begin
      cell_q <= cell_d;
    end
  end
endmodule

// File: rtl/dotmx_glyph.sv
module dotmx_glyph
  import dotmx_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DOTS-1:0]   dots
);
  glyph_t full;

  always_comb full = glyph_of(code);

  // One row slice per generate pass; keeps the row/column mapping explicit.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign dots[r*COLS + c] = full[r*COLS + c];
    end
  end
endmodule

// File: rtl/dotmx_char.sv
module dotmx_char
  import dotmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_n,
  input  logic [CODE_W-1:0] bcd_in,
  input  logic              dp_n,
  output logic [DOTS-1:0]   dots_o,
  output logic              dp_o
);
  cell_t cell_q;

  dotmx_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .le_n    (le_n),
    .code_in (bcd_in),
    .dp_n    (dp_n),
    .cell_q  (cell_q)
  );

  dotmx_glyph u_glyph (
    .code (cell_q.code),
    .dots (dots_o)
  );

  assign dp_o = cell_q.dp;
endmodule

// File: rtl/dotmx_char_chk.sv
module dotmx_char_chk
  import dotmx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              le_n,
  input logic [CODE_W-1:0] bcd_in,
  input logic              dp_n,
  input logic [DOTS-1:0]   dots_o,
  input logic              dp_o
);
  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |=> (dots_o == '0 && !dp_o)); // R1

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    le_n |=> ($stable(dots_o) && $stable(dp_o))); // R3

  AST_DP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !le_n |=> (dp_o == !$past(dp_n))); // R8

  AST_MINUS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && bcd_in == CODE_MINUS) |=> (dots_o == 28'h000F000)); // R5

  AST_TEST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && bcd_in == CODE_TEST) |=> (&dots_o)); // R6

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && bcd_in > 4'd10 && bcd_in < 4'd15) |=> (dots_o == '0)); // R7

  AST_DIGIT_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && bcd_in < 4'd10) |=> ($countones(dots_o) > 6)); // R4
endmodule

bind dotmx_char dotmx_char_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .le_n   (le_n),
  .bcd_in (bcd_in),
  .dp_n   (dp_n),
  .dots_o (dots_o),
  .dp_o   (dp_o)
);

// File: tb/dotmx_char_bench.sv
module dotmx_char_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        le_n = 1'b1;
  logic [3:0]  bcd_in = 4'd0;
  logic        dp_n = 1'b1;
  logic [27:0] dots_o;
  logic        dp_o;

  int n_chk = 0;
  int n_bad = 0;

  // Behavioural reference: stored code and lit-dp flag.
  int ref_code = 11;
  int ref_dp   = 0;

  always #4 clk = ~clk; // 125 MHz

  dotmx_char u_dotmx_char (
    .clk(clk), .rst_n(rst_n), .le_n(le_n), .bcd_in(bcd_in),
    .dp_n(dp_n), .dots_o(dots_o), .dp_o(dp_o)
  );

  function automatic logic [27:0] exp_glyph(input int c);
    logic [27:0] digits [10] = '{28'h6999996, 28'hE444464, 28'hF124896,
      28'h6986896, 28'h888F999, 28'h698871F, 28'h6997116, 28'h222448F,
      28'h6996996, 28'h688E996};
    if (c < 10) return digits[c];
    if (c == 10) return 28'h000F000;
    if (c == 15) return 28'hFFFFFFF;
    return 28'h0;
  endfunction

  function automatic string tag_of(input int c);
    if (c < 10) return "R4";
    if (c == 10) return "R5";
    if (c == 15) return "R6";
    return "R7";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_code <= 11;
      ref_dp   <= 0;
    end else if (!le_n) begin
      ref_code <= int'(bcd_in);
      ref_dp   <= (dp_n == 1'b0) ? 1 : 0;
    end
  end

  task automatic chk_out(input string tag);
    n_chk++;
    if (dots_o !== exp_glyph(ref_code)) begin
      n_bad++;
      $display("FAIL %s dots: actual %h expected %h (code %0d)",
               tag, dots_o, exp_glyph(ref_code), ref_code);
    end
    n_chk++;
    if (dp_o !== ref_dp[0]) begin
      n_bad++;
      $display("FAIL R8 dp (%s): actual %b expected %b", tag, dp_o, ref_dp[0]);
    end
  endtask

  // Compare on every clock, away from the active edge.
  logic cmp_on = 1'b0;
  logic prev_le_n = 1'b1;
  always @(negedge clk) begin
    if (cmp_on) chk_out(prev_le_n ? "R3" : {"R2/", tag_of(ref_code)});
    prev_le_n = le_n;
  end

  task automatic step(input logic le, input logic [3:0] c, input logic d);
    @(negedge clk);
    le_n = le; bcd_in = c; dp_n = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (dots_o !== 28'h0 || dp_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %h/%b expected 0/0", dots_o, dp_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    // R4 R5 R6 R7 R8: every code, dp alternating, latch open
    for (int c = 0; c < 16; c++) step(1'b0, 4'(c), c[0]);
    // R3: close and wiggle data
    step(1'b0, 4'd8, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 4'($urandom_range(15)), 1'($urandom_range(1)));
    // R2/R3 capture edge: close while data changes in the same cycle
    step(1'b0, 4'd3, 1'b1);
    step(1'b1, 4'd10, 1'b0);
    step(1'b1, 4'd10, 1'b0);
    step(1'b0, 4'd15, 1'b0);
    step(1'b1, 4'd2, 1'b1);
    step(1'b1, 4'd2, 1'b1);
    // Mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(1)), 4'($urandom_range(15)), 1'($urandom_range(1)));
    // R1: reset mid-run returns to blank, dp off
    step(1'b1, 4'd0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 4'd1, 1'b0);
    step(1'b1, 4'd1, 1'b0);
    cmp_on = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule